// File: doc/BRIEF.md
# Root Hub Downstream Port Status Registers

This block holds the status and control word of every downstream port of a USB root hub, together with a small hub-wide status word. Software reaches all of them through a plain word-addressed register port. Writes are not stored as they arrive. Each bit written as 1 is a command. Depending on its position, it clears a change flag, disables the port, requests enable, suspend or reset, or switches port power. Bits written as 0 do nothing.

The port side delivers attach and detach pulses and a low-speed indication for each port. The block keeps the connection state, the flags and the change bits up to date. A port reset finishes in a single step: the block pulses a per-port device-reset output and marks the port as enabled. Any change to a port word or to the hub word raises a one-cycle root-hub status-change event. An attach while the controller is suspended also raises a resume-detect event.

Top module: `hub_root_ports`

## Requirements
- R1: After reset, every port word and the hub word read as zero, and `dev_reset`, `rh_change` and `resume_detect` are low.
- R2: Port word layout: bit 0 connected, bit 1 enabled, bit 2 suspended, bit 3 over-current, bit 4 reset active, bit 8 powered, bit 9 low-speed. Change flags sit at bit 16 (connect), 17 (enable), 18 (suspend), 19 (over-current) and 20 (reset). Writing 1 to any of bits 16 to 20 clears that flag.
- R3: Writing 1 to bit 0 of a port word clears its enabled bit.
- R4: Writing 1 to bit 1, 2 or 4 of a port that is not connected leaves that bit clear and sets the connect-change flag (bit 16). On a connected port, bits 1 and 2 become set. A port is never enabled while it is disconnected.
- R5: Writing 1 to bit 4 of a connected port raises that port's `dev_reset` bit for exactly one cycle, starting in the cycle after the write. In the same cycle the port reads with bit 4 clear and bits 1 and 20 set. Bit 4 never reads as 1.
- R6: Writing 1 to bit 8 powers the port on and writing 1 to bit 9 powers it off. When both are written together, the port ends up powered off.
- R7: An attach pulse sets bits 0 and 16 and copies `dev_lowspeed` into bit 9. If `hc_suspended` is high at the attach, `resume_detect` pulses in the next cycle.
- R8: A detach pulse on a connected port clears bit 0 and sets bit 16. If the port was enabled, it also clears bit 1 and sets bit 17.
- R9: The hub word sits at byte offset 0x50. Writing bit 0 powers off every port and writing bit 16 powers on every port. Writing bit 15 sets remote-wakeup enable (read at bit 15), and writing bit 31 clears it; clear wins when both are written. The over-current change flag (read at bit 17) is set by `hub_ovc_evt` and cleared by writing bit 17.
- R10: `rh_change` is high for one cycle, in the cycle after an edge at which any port word or the hub word changed. It stays low otherwise.
- R11: Port k sits at byte offset 0x54 + 4k. An offset past the configured port count, or a misaligned offset, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write command bits |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| dev_attach | input | N_PORTS | Per-port attach pulse |
| dev_detach | input | N_PORTS | Per-port detach pulse |
| dev_lowspeed | input | N_PORTS | Per-port low-speed indication, sampled on attach |
| hc_suspended | input | 1 | Controller is in the suspended state |
| hub_ovc_evt | input | 1 | Sets the hub over-current change flag |
| dev_reset | output | N_PORTS | One-cycle device reset request per port |
| rh_change | output | 1 | Root-hub status-change event |
| resume_detect | output | 1 | Resume-detect event |

## Verification
The assertions watch several properties on every cycle. A port is never enabled while disconnected, and the reset bit never stays set. Each device-reset pulse leaves its port enabled with the reset-change flag set, and at most one port is reset at a time. The status-change event matches exactly the cycles that follow a register change, and resume-detect only fires after a suspended attach. The bench scenarios are needed for the command encoding itself. They show which write bit clears or sets which flag, that power-off wins, the connect-change fallback on unconnected ports, detach clean-up, the hub-wide power and wake commands, and the address map boundaries.

// File: rtl/hub_regs_pkg.sv
package hub_regs_pkg;

  localparam int B_CONN     = 0;
  localparam int B_ENA      = 1;
  localparam int B_SUSP     = 2;
  localparam int B_RST      = 4;
  localparam int B_PWR      = 8;
  localparam int B_LOWSPD   = 9;
  localparam int B_CONN_CHG = 16;
  localparam int B_ENA_CHG  = 17;
  localparam int B_RST_CHG  = 20;

  localparam logic [31:0] CHG_MASK = 32'h001F_0000;

  localparam int HB_PWR_OFF  = 0;
  localparam int HB_WAKE_SET = 15;
  localparam int HB_PWR_ON   = 16;
  localparam int HB_OVC_CLR  = 17;
  localparam int HB_WAKE_CLR = 31;

  localparam int HUB_BYTE_OFS  = 'h50;
  localparam int PORT_BYTE_OFS = 'h54;

  typedef struct packed {
    logic [31:0] val;
    logic        fire;
  } port_upd_t;

  // Set a command bit only when connected; otherwise flag a connect change.
  function automatic logic [31:0] set_if_conn(logic [31:0] cur, int pos);
    logic [31:0] v;
    v = cur;
    if (cur[B_CONN]) v[pos] = 1'b1;
    else             v[B_CONN_CHG] = 1'b1;
    return v;
  endfunction

  // Apply a software command word to one port status word.
  function automatic port_upd_t port_apply_write(logic [31:0] cur, logic [31:0] wd);
    port_upd_t r;
    logic [31:0] v;
    v = cur & ~(wd & CHG_MASK);
    if (wd[B_CONN]) v[B_ENA] = 1'b0;
    if (wd[B_ENA])  v = set_if_conn(v, B_ENA);
    if (wd[B_SUSP]) v = set_if_conn(v, B_SUSP);
    r.fire = wd[B_RST] && v[B_CONN];
    if (wd[B_RST])  v = set_if_conn(v, B_RST);
    if (r.fire) begin
      v[B_RST]     = 1'b0;
      v[B_ENA]     = 1'b1;
      v[B_RST_CHG] = 1'b1;
    end
    if (wd[B_LOWSPD])   v[B_PWR] = 1'b0;
    else if (wd[B_PWR]) v[B_PWR] = 1'b1;
    r.val = v;
    return r;
  endfunction

  // Apply attach / detach indications; attach takes precedence.
  function automatic logic [31:0] port_apply_event(logic [31:0] cur, logic att,
                                                   logic det, logic ls);
    logic [31:0] v;
    v = cur;
    if (att) begin
      v[B_CONN]     = 1'b1;
      v[B_CONN_CHG] = 1'b1;
      v[B_LOWSPD]   = ls;
    end else if (det) begin
      if (v[B_CONN]) begin
        v[B_CONN]     = 1'b0;
        v[B_CONN_CHG] = 1'b1;
      end
      if (v[B_ENA]) begin
        v[B_ENA]     = 1'b0;
        v[B_ENA_CHG] = 1'b1;
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/hub_port_slot.sv
module hub_port_slot
  import hub_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        pwr_all_off,
  input  logic        pwr_all_on,
  input  logic        attach,
  input  logic        detach,
  input  logic        lowspeed,
  output logic [31:0] status,
  output logic        reset_fire,
  output logic        changed
);

  port_upd_t   upd;
  logic [31:0] nxt;

  always_comb begin
    upd        = port_apply_write(status, wr_data);
    nxt        = status;
    reset_fire = 1'b0;
    if (wr_sel) begin
      nxt        = upd.val;
      reset_fire = upd.fire;
    end
    if (pwr_all_off)     nxt[B_PWR] = 1'b0;
    else if (pwr_all_on) nxt[B_PWR] = 1'b1;
    nxt = port_apply_event(nxt, attach, detach, lowspeed);
  end

  assign changed = (nxt != status);

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= nxt;
  end

endmodule

// File: rtl/hub_global_status.sv
module hub_global_status
  import hub_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        ovc_evt,
  output logic        wake_en,
  output logic        ovc_chg,
  output logic        pwr_all_off,
  output logic        pwr_all_on,
  output logic        changed
);

  logic wake_nxt, ovc_nxt;

  always_comb begin
    wake_nxt = wake_en;
    ovc_nxt  = ovc_chg;
    if (wr_sel) begin
      if (wr_data[HB_WAKE_CLR])      wake_nxt = 1'b0;
      else if (wr_data[HB_WAKE_SET]) wake_nxt = 1'b1;
      if (wr_data[HB_OVC_CLR])       ovc_nxt  = 1'b0;
    end
    if (ovc_evt) ovc_nxt = 1'b1;
  end

  assign pwr_all_off = wr_sel && wr_data[HB_PWR_OFF];
  assign pwr_all_on  = wr_sel && wr_data[HB_PWR_ON] && !wr_data[HB_PWR_OFF];
  assign changed     = (wake_nxt != wake_en) || (ovc_nxt != ovc_chg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_en <= 1'b0;
      ovc_chg <= 1'b0;
    end else begin
      wake_en <= wake_nxt;
      ovc_chg <= ovc_nxt;
    end
  end

endmodule

// File: rtl/hub_root_ports.sv
module hub_root_ports
  import hub_regs_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [N_PORTS-1:0] dev_attach,
  input  logic [N_PORTS-1:0] dev_detach,
  input  logic [N_PORTS-1:0] dev_lowspeed,
  input  logic               hc_suspended,
  input  logic               hub_ovc_evt,
  output logic [N_PORTS-1:0] dev_reset,
  output logic               rh_change,
  output logic               resume_detect
);

  localparam int WORD_W    = ADDR_W - 2;
  localparam int HUB_WORD  = HUB_BYTE_OFS / 4;
  localparam int PORT_WORD = PORT_BYTE_OFS / 4;

  logic [WORD_W-1:0]     word_idx;
  logic                  aligned;
  logic                  hub_sel;
  logic [N_PORTS-1:0]    port_sel;
  logic [N_PORTS-1:0]    port_fire;
  logic [N_PORTS-1:0]    port_changed;
  logic [N_PORTS*32-1:0] port_flat;
  logic [1:0]            hub_bits;
  logic                  hub_changed, pwr_off, pwr_on;
  logic                  wake_en, ovc_chg;

  assign word_idx = reg_addr[ADDR_W-1:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign hub_sel  = aligned && (word_idx == WORD_W'(HUB_WORD));

  hub_global_status u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (reg_wr && hub_sel),
    .wr_data    (reg_wdata),
    .ovc_evt    (hub_ovc_evt),
    .wake_en    (wake_en),
    .ovc_chg    (ovc_chg),
    .pwr_all_off(pwr_off),
    .pwr_all_on (pwr_on),
    .changed    (hub_changed)
  );
  assign hub_bits = {ovc_chg, wake_en};

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    assign port_sel[i] = aligned && (word_idx == WORD_W'(PORT_WORD + i));
    hub_port_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sel     (reg_wr && port_sel[i]),
      .wr_data    (reg_wdata),
      .pwr_all_off(pwr_off),
      .pwr_all_on (pwr_on),
      .attach     (dev_attach[i]),
      .detach     (dev_detach[i]),
      .lowspeed   (dev_lowspeed[i]),
      .status     (port_flat[i*32 +: 32]),
      .reset_fire (port_fire[i]),
      .changed    (port_changed[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (hub_sel) begin
      reg_rdata[HB_OVC_CLR]  = ovc_chg;
      reg_rdata[HB_WAKE_SET] = wake_en;
    end
    for (int i = 0; i < N_PORTS; i++)
      if (port_sel[i]) reg_rdata = port_flat[i*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_reset     <= '0;
      rh_change     <= 1'b0;
      resume_detect <= 1'b0;
    end else begin
      dev_reset     <= port_fire;
      rh_change     <= (|port_changed) || hub_changed;
      resume_detect <= (|dev_attach) && hc_suspended;
    end
  end

endmodule

// File: rtl/hub_root_ports_chk.sv
module hub_root_ports_chk #(
  parameter int N_PORTS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PORTS*32-1:0] port_flat,
  input logic [1:0]         hub_bits,
  input logic [N_PORTS-1:0] dev_reset,
  input logic               rh_change,
  input logic               resume_detect,
  input logic               hc_suspended,
  input logic [N_PORTS-1:0] dev_attach
);

  assert_reset_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_reset));

  for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
    assert_enable_needs_conn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      port_flat[i*32+1] |-> port_flat[i*32+0]);
    assert_reset_bit_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !port_flat[i*32+4]);
    assert_reset_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_reset[i] |-> (port_flat[i*32+1] && port_flat[i*32+20]));
    assert_reset_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_reset[i] |=> !dev_reset[i]);
  end

  assert_change_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rh_change == (!$stable(port_flat) || !$stable(hub_bits)));

  assert_resume_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_detect |-> ($past(hc_suspended) && $past(|dev_attach)));

endmodule

bind hub_root_ports hub_root_ports_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .port_flat    (port_flat),
  .hub_bits     (hub_bits),
  .dev_reset    (dev_reset),
  .rh_change    (rh_change),
  .resume_detect(resume_detect),
  .hc_suspended (hc_suspended),
  .dev_attach   (dev_attach)
);

// File: tb/test_hub_root_ports.sv
`timescale 1ns/1ps
module test_hub_root_ports;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] dev_attach = '0, dev_detach = '0, dev_lowspeed = '0;
  logic          hc_suspended = 1'b0, hub_ovc_evt = 1'b0;
  logic [NP-1:0] dev_reset;
  logic          rh_change, resume_detect;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hub_root_ports #(.N_PORTS(NP), .ADDR_W(8)) i_hub_root_ports (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_attach(dev_attach),
    .dev_detach(dev_detach), .dev_lowspeed(dev_lowspeed),
    .hc_suspended(hc_suspended), .hub_ovc_evt(hub_ovc_evt),
    .dev_reset(dev_reset), .rh_change(rh_change), .resume_detect(resume_detect)
  );

  // {addr, write data, expected read at addr, expected rh_change}
  localparam logic [72:0] VEC [9] = '{
    {8'h54, 32'h0000_0002, 32'h0001_0000, 1'b1}, // R4 enable on unconnected
    {8'h54, 32'h0001_0000, 32'h0000_0000, 1'b1}, // R2 clear connect change
    {8'h54, 32'h0000_0100, 32'h0000_0100, 1'b1}, // R6 power on
    {8'h54, 32'h0000_0100, 32'h0000_0100, 1'b0}, // R10 no change
    {8'h54, 32'h0000_0300, 32'h0000_0000, 1'b1}, // R6 off wins
    {8'h54, 32'h0000_0100, 32'h0000_0100, 1'b1}, // R6 power on again
    {8'h58, 32'h0000_0004, 32'h0001_0000, 1'b1}, // R4 suspend unconnected, R11 port 1
    {8'h64, 32'h0000_0100, 32'h0000_0000, 1'b0}, // R11 beyond port count
    {8'h55, 32'h0000_0200, 32'h0000_0000, 1'b0}  // R11 misaligned
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_evt(bit att, int k, bit ls);
    @(negedge clk);
    if (att) begin dev_attach[k] = 1'b1; dev_lowspeed[k] = ls; end
    else     dev_detach[k] = 1'b1;
    @(negedge clk);
    dev_attach = '0; dev_detach = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < NP; k++) begin
      rd(8'(8'h54 + 4*k), v);
      check("R1 port word", v, 32'h0);
    end
    rd(8'h50, v);                     check("R1 hub word", v, 32'h0);
    check("R1 outputs", {29'h0, rh_change, resume_detect, |dev_reset}, 32'h0);

    // Table walk
    for (int n = 0; n < 9; n++) begin
      wr(VEC[n][72:65], VEC[n][64:33]);
      check($sformatf("R10 vec%0d rh_change", n), {31'h0, rh_change}, {31'h0, VEC[n][0]});
      rd(VEC[n][72:65], v);
      check($sformatf("R2/R4/R6/R11 vec%0d read", n), v, VEC[n][32:1]);
    end

    // R7 attach low-speed while suspended
    hc_suspended = 1'b1;
    pulse_evt(1'b1, 0, 1'b1);
    check("R7 resume_detect", {31'h0, resume_detect}, 32'h1);
    check("R10 attach rh_change", {31'h0, rh_change}, 32'h1);
    rd(8'h54, v);                     check("R7 attach p0", v, 32'h0001_0301);
    hc_suspended = 1'b0;

    wr(8'h54, 32'h0001_0000);
    rd(8'h54, v);                     check("R2 clear csc", v, 32'h0000_0301);

    // R5 port reset
    wr(8'h54, 32'h0000_0010);
    check("R5 dev_reset pulse", {28'h0, dev_reset}, 32'h1);
    rd(8'h54, v);                     check("R5 reset done", v, 32'h0010_0303);
    @(negedge clk);
    check("R5 dev_reset one cycle", {28'h0, dev_reset}, 32'h0);

    wr(8'h54, 32'h0010_0000);
    rd(8'h54, v);                     check("R2 clear reset change", v, 32'h0000_0303);
    wr(8'h54, 32'h0000_0004);
    rd(8'h54, v);                     check("R4 suspend connected", v, 32'h0000_0307);
    wr(8'h54, 32'h0000_0001);
    rd(8'h54, v);                     check("R3 disable", v, 32'h0000_0305);
    wr(8'h54, 32'h0000_0002);
    rd(8'h54, v);                     check("R4 enable connected", v, 32'h0000_0307);

    // R8 detach of enabled port
    pulse_evt(1'b0, 0, 1'b0);
    check("R7 no resume when running", {31'h0, resume_detect}, 32'h0);
    rd(8'h54, v);                     check("R8 detach", v, 32'h0003_0304);

    // R9 hub word
    wr(8'h50, 32'h0000_8000);
    rd(8'h50, v);                     check("R9 wake set", v, 32'h0000_8000);
    wr(8'h50, 32'h8000_8000);
    rd(8'h50, v);                     check("R9 wake clear wins", v, 32'h0);
    @(negedge clk); hub_ovc_evt = 1'b1;
    @(negedge clk); hub_ovc_evt = 1'b0;
    rd(8'h50, v);                     check("R9 ovc change set", v, 32'h0002_0000);
    wr(8'h50, 32'h0002_0000);
    rd(8'h50, v);                     check("R9 ovc change clear", v, 32'h0);
    wr(8'h50, 32'h0001_0000);
    check("R10 power-all rh_change", {31'h0, rh_change}, 32'h1);
    rd(8'h58, v);                     check("R9 power all on p1", v, 32'h0001_0100);
    rd(8'h60, v);                     check("R9 power all on p3", v, 32'h0000_0100);
    wr(8'h50, 32'h0000_0001);
    rd(8'h60, v);                     check("R9 power all off p3", v, 32'h0);
    rd(8'h54, v);                     check("R9 power all off p0", v, 32'h0003_0204);

    // R7 full-speed attach on port 2, not suspended
    pulse_evt(1'b1, 2, 1'b0);
    check("R7 no resume", {31'h0, resume_detect}, 32'h0);
    rd(8'h5C, v);                     check("R7 attach p2", v, 32'h0001_0001);
    @(negedge clk);
    check("R10 idle", {31'h0, rh_change}, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule